// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register side of a memory-mapped general-purpose I/O controller. Pins are grouped into banks of 32, and the number of banks is a parameter. Each bank has a register for the output values and one for the sampled input values. Outputs are changed through separate write-one-to-set and write-one-to-clear registers. Each bank also has a write-one-to-clear event status register and an interrupt mask, which is changed through its own set and clear registers. Every pin has its own control word that selects its direction.

Edge detection and debounce sit outside this block. They deliver one event pulse per pin, and a pulse sets that pin's status bit. Each bank raises its own interrupt line while at least one of its status bits is set and not masked. Register access is a simple synchronous write port with a combinational read port on the same byte address.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, all pin outputs are 0 and all pins are inputs (output enable 0). All mask bits read 1, all status bits read 0, and no interrupt line is high.
- R2: The per-pin control word for pin n is at address 0x100 + 4*n. Bit 0 = 1 makes the pin an input (output enable 0), and bit 0 = 0 makes it an output (output enable 1). A read returns the direction in bit 0 and 0 in all other bits. The change takes effect on the clock edge of the write.
- R3: Pin n belongs to bank n>>5 at bit n&31. Bank b's output register drives pin_out_o[32*b+31:32*b].
- R4: Writing a 1 to bit i of the output-set register (0x40 + 4*b) drives that pin high. Writing a 1 to bit i of the output-clear register (0x60 + 4*b) drives it low. Zero bits have no effect. The output values read back at 0x00 + 4*b.
- R5: A read at 0x20 + 4*b returns bank b's pin inputs as sampled at the previous clock edge.
- R6: An event pulse sets the pin's status bit. Writing a 1 to that bit at 0x80 + 4*b clears it, and zero bits have no effect. An event in the same cycle as a clear of the same bit leaves the bit set.
- R7: Writing a 1 to bit i at 0xA0 + 4*b masks the pin, and writing a 1 at 0xC0 + 4*b unmasks it. Zero bits have no effect. Reads at either address return the mask.
- R8: The interrupt line of bank b is high from the cycle after any status bit is set and unmasked, and it goes low in the cycle after no such bit remains.
- R9: The set and clear registers read as 0. Addresses that fall outside the mapped registers (for example a bank number of NUM_BANKS or more) read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for addr_i / wdata_i |
| addr_i | input | 12 | Byte address for writes and reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_in_i | input | 32*NUM_BANKS | Pin input levels |
| event_i | input | 32*NUM_BANKS | Per-pin event pulses from edge detection |
| pin_out_o | output | 32*NUM_BANKS | Pin output values |
| pin_oe_o | output | 32*NUM_BANKS | Pin output enables |
| irq_o | output | NUM_BANKS | One interrupt line per bank |

## Verification
Corrupted output or direction state appears on pin_out_o or pin_oe_o one edge after the write that caused it. Readback of the output register then confirms which bank and bit were affected. A wrong status or mask bit appears on the bank's irq_o in the very next cycle. It also appears in the status and mask readback, including the case where an event and a clear land on the same edge. Writes that are decoded wrongly show up as changes in a neighbouring bank, or as nonzero data read from unmapped addresses.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned BANK_BITS = 32;
  localparam logic [ADDR_W-1:0] PIN_BASE = 12'h100;

  // Register kind is address bits [7:5] of the bank region
  typedef enum logic [2:0] {
    K_OUT  = 3'd0,
    K_IN   = 3'd1,
    K_SET  = 3'd2,
    K_CLR  = 3'd3,
    K_STAT = 3'd4,
    K_MSK  = 3'd5,
    K_MCLR = 3'd6,
    K_NONE = 3'd7
  } reg_kind_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned NPINS  = NUM_BANKS * BANK_BITS,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned PIN_W  = $clog2(NPINS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bank_hit_o,
  output logic [BANK_W-1:0] bank_idx_o,
  output reg_kind_e         kind_o,
  output logic              pin_hit_o,
  output logic [PIN_W-1:0]  pin_idx_o
);
  logic [2:0]        bank_field;
  logic [ADDR_W-1:0] pin_off;
  logic [9:0]        pin_field;

  always_comb begin
    bank_field = addr_i[4:2];
    kind_o     = reg_kind_e'(addr_i[7:5]);
    bank_hit_o = (addr_i[11:8] == 4'h0) && (kind_o != K_NONE) &&
                 (32'(bank_field) < NUM_BANKS);
    bank_idx_o = BANK_W'(bank_field);

    pin_off    = addr_i - PIN_BASE;
    pin_field  = pin_off[11:2];
    pin_hit_o  = (addr_i[11:8] != 4'h0) && (32'(pin_field) < NPINS);
    pin_idx_o  = pin_field[PIN_W-1:0];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  reg_kind_e            kind_i,
  input  logic [BANK_BITS-1:0] wdata_i,
  input  logic [BANK_BITS-1:0] pin_in_i,
  input  logic [BANK_BITS-1:0] event_i,
  output logic [BANK_BITS-1:0] out_o,
  output logic [BANK_BITS-1:0] in_q_o,
  output logic [BANK_BITS-1:0] stat_o,
  output logic [BANK_BITS-1:0] mask_o,
  output logic                 irq_o
);
  logic [BANK_BITS-1:0] stat_clr;

  assign stat_clr = (wr_en_i && kind_i == K_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o  <= '0;
      in_q_o <= '0;
      stat_o <= '0;
      mask_o <= '1;
    end else begin
      in_q_o <= pin_in_i;
      // event beats a same-cycle clear
      stat_o <= (stat_o & ~stat_clr) | event_i;
      if (wr_en_i) begin
        unique case (kind_i)
          K_SET:   out_o  <= out_o | wdata_i;
          K_CLR:   out_o  <= out_o & ~wdata_i;
          K_MSK:   mask_o <= mask_o | wdata_i;
          K_MCLR:  mask_o <= mask_o & ~wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign irq_o = |(stat_o & ~mask_o);
endmodule

// File: rtl/gpio_pin_dir.sv
module gpio_pin_dir #(
  parameter int unsigned NPINS = 64,
  localparam int unsigned PIN_W = $clog2(NPINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PIN_W-1:0] pin_idx_i,
  input  logic             dir_in_i,
  output logic [NPINS-1:0] dir_in_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 dir_in_o[p] <= 1'b1;
      else if (wr_en_i && 32'(pin_idx_i) == p)     dir_in_o[p] <= dir_in_i;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned NPINS  = NUM_BANKS * BANK_BITS,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned PIN_W  = $clog2(NPINS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPINS-1:0]  pin_in_i,
  input  logic [NPINS-1:0]  event_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic [NUM_BANKS-1:0] irq_o
);
  logic              bank_hit, pin_hit;
  logic [BANK_W-1:0] bank_idx;
  reg_kind_e         kind;
  logic [PIN_W-1:0]  pin_idx;
  logic [NPINS-1:0]  dir_in;

  logic [BANK_BITS-1:0] out_w  [NUM_BANKS];
  logic [BANK_BITS-1:0] in_w   [NUM_BANKS];
  logic [BANK_BITS-1:0] stat_w [NUM_BANKS];
  logic [BANK_BITS-1:0] mask_w [NUM_BANKS];

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i     (addr_i),
    .bank_hit_o (bank_hit),
    .bank_idx_o (bank_idx),
    .kind_o     (kind),
    .pin_hit_o  (pin_hit),
    .pin_idx_o  (pin_idx)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i && bank_hit && 32'(bank_idx) == b),
      .kind_i   (kind),
      .wdata_i  (wdata_i),
      .pin_in_i (pin_in_i[b*BANK_BITS +: BANK_BITS]),
      .event_i  (event_i[b*BANK_BITS +: BANK_BITS]),
      .out_o    (out_w[b]),
      .in_q_o   (in_w[b]),
      .stat_o   (stat_w[b]),
      .mask_o   (mask_w[b]),
      .irq_o    (irq_o[b])
    );
    assign pin_out_o[b*BANK_BITS +: BANK_BITS] = out_w[b];
  end

  gpio_pin_dir #(.NPINS(NPINS)) u_dir (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i && pin_hit),
    .pin_idx_i (pin_idx),
    .dir_in_i  (wdata_i[0]),
    .dir_in_o  (dir_in)
  );

  assign pin_oe_o = ~dir_in;

  always_comb begin
    rdata_o = '0;
    if (bank_hit) begin
      unique case (kind)
        K_OUT:         rdata_o = out_w[bank_idx];
        K_IN:          rdata_o = in_w[bank_idx];
        K_STAT:        rdata_o = stat_w[bank_idx];
        K_MSK, K_MCLR: rdata_o = mask_w[bank_idx];
        default:       rdata_o = '0;
      endcase
    end else if (pin_hit) begin
      rdata_o = {31'b0, dir_in[pin_idx]};
    end
  end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned NPINS = NUM_BANKS * 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [11:0]          addr_i,
  input logic [31:0]          wdata_i,
  input logic [NPINS-1:0]     event_i,
  input logic [NPINS-1:0]     pin_out_o,
  input logic [NPINS-1:0]     pin_oe_o,
  input logic [NUM_BANKS-1:0] irq_o
);
  a_r4_out_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 12'h040) |=>
      ((pin_out_o[31:0] & $past(wdata_i)) == $past(wdata_i)));

  a_r4_out_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 12'h060) |=> ((pin_out_o[31:0] & $past(wdata_i)) == '0));

  a_r3_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pin_out_o));

  a_r2_oe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pin_oe_o));

  a_r8_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> ($past(|event_i[31:0]) ||
                         ($past(wr_en_i) && $past(addr_i) == 12'h0C0)));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .event_i   (event_i),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o),
  .irq_o     (irq_o)
);

// File: tb/gpio_bank_regs_tb_top.sv
module gpio_bank_regs_tb_top;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_in_i = '0;
  logic [NP-1:0] event_i = '0;
  logic [NP-1:0] pin_out_o, pin_oe_o;
  logic [NB-1:0] irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_bank_regs #(.NUM_BANKS(NB)) dut_i (.*);

  typedef struct packed {
    logic        rd;
    logic [11:0] addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h10C, 32'h0000_0000, 8'd2},  // R2 pin 3 -> output
    '{1'b1, 12'h10C, 32'h0000_0000, 8'd2},
    '{1'b0, 12'h040, 32'h0000_00F0, 8'd4},  // R4 set
    '{1'b1, 12'h000, 32'h0000_00F0, 8'd4},
    '{1'b0, 12'h060, 32'h0000_0030, 8'd4},  // R4 clear
    '{1'b1, 12'h000, 32'h0000_00C0, 8'd4},
    '{1'b0, 12'h044, 32'h8000_0001, 8'd3},  // R3 bank 1
    '{1'b1, 12'h044, 32'h0000_0000, 8'd9},  // R9 set reg reads 0
    '{1'b1, 12'h000, 32'h0000_00C0, 8'd3},
    '{1'b0, 12'h040, 32'h0000_0000, 8'd4},  // R4 zero bits
    '{1'b1, 12'h000, 32'h0000_00C0, 8'd4},
    '{1'b0, 12'h0C0, 32'h0000_0001, 8'd7},  // R7 unmask
    '{1'b1, 12'h0A0, 32'hFFFF_FFFE, 8'd7},
    '{1'b0, 12'h0A0, 32'h0000_0001, 8'd7},  // R7 mask
    '{1'b1, 12'h0C0, 32'hFFFF_FFFF, 8'd7},
    '{1'b0, 12'h048, 32'hFFFF_FFFF, 8'd9},  // R9 bank 2 does not exist
    '{1'b1, 12'h048, 32'h0000_0000, 8'd9}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr_i = a;
    #0.5;
    chk(req, 64'(rdata_o), 64'(exp));
  endtask

  task automatic pulse(input logic [NP-1:0] ev);
    @(negedge clk_i);
    event_i = ev;
    @(negedge clk_i);
    event_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 out", 64'(pin_out_o), 64'h0);
    chk("R1 oe", 64'(pin_oe_o), 64'h0);
    chk("R1 irq", 64'(irq_o), 64'h0);
    rd("R1 mask", 12'h0A4, 32'hFFFF_FFFF);
    rd("R1 stat", 12'h080, 32'h0);
    rd("R1 dir", 12'h100, 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) rd($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
      else            wr(VECS[i].addr, VECS[i].data);
    end

    chk("R2 oe pin3", 64'(pin_oe_o), 64'h8);
    chk("R3 bank1 out", 64'(pin_out_o[63:32]), 64'h8000_0001);
    wr(12'h18C, 32'h0);  // R2 pin 35
    chk("R2 oe pin35", 64'(pin_oe_o), 64'h0000_0008_0000_0008);
    wr(12'h18C, 32'hFFFF_FFFF);
    rd("R2 readback bit0 only", 12'h18C, 32'h1);

    // R5 input sampling
    @(negedge clk_i);
    pin_in_i = {32'h1234_5678, 32'hA5A5_0F0F};
    rd("R5 before edge", 12'h020, 32'h0);
    @(negedge clk_i);
    rd("R5 bank0", 12'h020, 32'hA5A5_0F0F);
    rd("R5 bank1", 12'h024, 32'h1234_5678);

    // R6 masked event sets status, no irq
    pulse(NP'(64'h20));
    rd("R6 stat", 12'h080, 32'h20);
    chk("R8 masked no irq", 64'(irq_o), 64'h0);
    wr(12'h080, 32'h20);
    rd("R6 w1c", 12'h080, 32'h0);

    // R8 unmasked bank1 bit0
    wr(12'h0C4, 32'h1);
    pulse(NP'(64'h1_0000_0000));
    chk("R8 irq bank1", 64'(irq_o), 64'h2);
    rd("R6 stat bank1", 12'h084, 32'h1);
    wr(12'h084, 32'h0);
    rd("R6 zero write", 12'h084, 32'h1);
    wr(12'h084, 32'h1);
    chk("R8 irq drop", 64'(irq_o), 64'h0);

    // R6 event and clear on the same edge
    @(negedge clk_i);
    event_i = NP'(64'h1_0000_0000);
    wr_en_i = 1'b1; addr_i = 12'h084; wdata_i = 32'h1;
    @(negedge clk_i);
    event_i = '0; wr_en_i = 1'b0;
    rd("R6 event wins", 12'h084, 32'h1);
    chk("R8 irq held", 64'(irq_o), 64'h2);
    wr(12'h0A4, 32'h1);
    chk("R7 mask gates irq", 64'(irq_o), 64'h0);
    rd("R9 unmapped pin", 12'h200, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule